// File: doc/BRIEF.md
# Marker-framed self-latching serial receiver

The block turns a two-wire serial stream, a shift clock and a data line, into parallel words without a separate load or strobe wire. The sender starts every word with a 1 marker bit and follows it with the payload bits. When that marker reaches the last stage of the shift chain, the block copies the remaining stages into a parallel output register. It then clears the chain on its own, so the next word can follow at once.

Both serial inputs are sampled by a fast system clock through synchronizer flops. A rising edge on the serial clock is detected in the system-clock domain and shifts one data bit in. Each frame passes through three steps on separate system-clock cycles: the marker is detected, the output register is loaded together with a one-cycle valid pulse, and the chain is cleared. A stretched copy of the valid pulse is also provided for slower consumers. Serial clock edges that arrive while this sequence runs are dropped, and a sticky flag records that they occurred.

Top module: `sentinel_rx`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `word_o`, `valid_o`, `valid_hold_o` and `overrun_o` are all 0.
- R2: Each rising edge of `sclk_i` shifts one bit of `sdata_i` into the chain. Falling edges have no effect. Bits travel from stage 0 toward stage CHAIN_LEN-1, so the first payload bit after the marker ends up in `word_o[CHAIN_LEN-2]` and the last payload bit ends up in `word_o[0]`.
- R3: A frame is a 1 marker followed by exactly CHAIN_LEN-1 payload bits. The capture fires when the marker occupies the final stage, and `word_o` then equals the payload.
- R4: `valid_o` is high for exactly one system-clock cycle per frame. With two synchronizer stages, this cycle comes no more than six system-clock cycles after the final rising edge of `sclk_i`.
- R5: `word_o` changes only in the cycle in which `valid_o` is high. It keeps the captured value while the chain is cleared and until the next capture.
- R6: After a capture, the chain returns to all zeros without any external action. The next frame is then received correctly, with no bits left over from the previous one.
- R7: `valid_hold_o` goes high in the same cycle as `valid_o` and stays high for HOLD_CYCLES consecutive cycles.
- R8: A rising `sclk_i` edge that arrives while the marker sits in the final stage, or during the capture or clear cycles, is not shifted in. Such an edge sets `overrun_o`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial shift clock, asynchronous to clk_i |
| sdata_i | input | 1 | Serial data, sampled on rising sclk_i |
| word_o | output | CHAIN_LEN-1 | Last captured payload word |
| valid_o | output | 1 | One-cycle strobe marking a new word |
| valid_hold_o | output | 1 | Valid strobe stretched to HOLD_CYCLES cycles |
| overrun_o | output | 1 | Sticky flag for dropped serial clock edges |

## Verification
The bench builds the block with CHAIN_LEN=8, so each word carries 7 payload bits. At that size the all-zero, all-one and alternating payloads are cheap to send, and the bit ordering can be checked on every position. HOLD_CYCLES is set to 3 rather than the default, so the stretch length is checked against a value that differs from the default. Two synchronizer stages keep the capture latency short enough that a second serial clock pulse, sent right after a frame, lands inside the capture window and exercises the overrun path.

// File: rtl/sentinel_rx_pkg.sv
package sentinel_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_CLR  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/sentinel_rx_sync.sv
module sentinel_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic rise_o,
  output logic data_o
);
  logic [STAGES-1:0] clk_sync_q, dat_sync_q;
  logic              clk_last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sync_q <= '0;
      dat_sync_q <= '0;
      clk_last_q <= 1'b0;
    end else begin
      clk_sync_q <= {clk_sync_q[STAGES-2:0], sclk_i};
      dat_sync_q <= {dat_sync_q[STAGES-2:0], sdata_i};
      clk_last_q <= clk_sync_q[STAGES-1];
    end
  end

  assign rise_o = clk_sync_q[STAGES-1] & ~clk_last_q;
  assign data_o = dat_sync_q[STAGES-1];
endmodule

// File: rtl/sentinel_rx_chain.sv
module sentinel_rx_chain #(
  parameter int unsigned LEN = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shift_i,
  input  logic           bit_i,
  input  logic           clear_i,
  output logic [LEN-1:0] chain_o
);
  logic [LEN-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_q <= '0;
    else if (clear_i) stage_q <= '0;
    else if (shift_i) stage_q <= {stage_q[LEN-2:0], bit_i};
  end

  assign chain_o = stage_q;
endmodule

// File: rtl/sentinel_rx_stretch.sv
module sentinel_rx_stretch #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic hold_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (trig_i)         cnt_q <= CW'(HOLD);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = (cnt_q != '0);
endmodule

// File: rtl/sentinel_rx.sv
module sentinel_rx
  import sentinel_rx_pkg::*;
#(
  parameter int unsigned CHAIN_LEN   = 8,
  parameter int unsigned HOLD_CYCLES = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 sdata_i,
  output logic [CHAIN_LEN-2:0] word_o,
  output logic                 valid_o,
  output logic                 valid_hold_o,
  output logic                 overrun_o
);
  localparam int unsigned DATA_W = CHAIN_LEN - 1;

  rx_state_e         state_q, state_d;
  logic              rise, sdata_s, busy, shift_en, clear;
  logic [CHAIN_LEN-1:0] chain_q;
  logic [DATA_W-1:0] word_q;
  logic              valid_q, overrun_q;

  sentinel_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (sclk_i),
    .sdata_i (sdata_i),
    .rise_o  (rise),
    .data_o  (sdata_s)
  );

  // marker in last stage or sequence running: chain is frozen
  assign busy     = (state_q != ST_IDLE) | chain_q[CHAIN_LEN-1];
  assign shift_en = rise & ~busy;
  assign clear    = (state_q == ST_CLR);

  sentinel_rx_chain #(.LEN(CHAIN_LEN)) i_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_en),
    .bit_i   (sdata_s),
    .clear_i (clear),
    .chain_o (chain_q)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (chain_q[CHAIN_LEN-1]) state_d = ST_CAPT;
      ST_CAPT: state_d = ST_CLR;
      ST_CLR:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      word_q    <= '0;
      valid_q   <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= (state_q == ST_CAPT);
      if (state_q == ST_CAPT) word_q <= chain_q[DATA_W-1:0];
      if (rise && busy)       overrun_q <= 1'b1;
    end
  end

  sentinel_rx_stretch #(.HOLD(HOLD_CYCLES)) i_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (state_q == ST_CAPT),
    .hold_o (valid_hold_o)
  );

  assign word_o    = word_q;
  assign valid_o   = valid_q;
  assign overrun_o = overrun_q;
endmodule

// File: rtl/sentinel_rx_chk.sv
module sentinel_rx_chk #(
  parameter int unsigned CHAIN_LEN = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [CHAIN_LEN-2:0] word_o,
  input logic                 valid_o,
  input logic                 valid_hold_o,
  input logic                 overrun_o,
  input logic [CHAIN_LEN-1:0] chain_i
);
  a_r4_single_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r5_word_only_on_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> valid_o);

  a_r6_chain_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> (chain_i == '0));

  a_r7_hold_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> valid_hold_o);

  a_r8_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  a_r1_reset_outputs: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !valid_hold_o && !overrun_o && word_o == '0));
endmodule

bind sentinel_rx sentinel_rx_chk #(.CHAIN_LEN(CHAIN_LEN)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_o       (word_o),
  .valid_o      (valid_o),
  .valid_hold_o (valid_hold_o),
  .overrun_o    (overrun_o),
  .chain_i      (chain_q)
);

// File: tb/test_sentinel_rx.sv
module test_sentinel_rx;
  localparam int unsigned LEN  = 8;
  localparam int unsigned DW   = LEN - 1;
  localparam int unsigned HOLD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic sdata = 1'b0;
  logic [DW-1:0] word;
  logic valid, vhold, ovr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sentinel_rx #(.CHAIN_LEN(LEN), .HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) i_sentinel_rx (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sclk_i       (sclk),
    .sdata_i      (sdata),
    .word_o       (word),
    .valid_o      (valid),
    .valid_hold_o (vhold),
    .overrun_o    (ovr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bit sent at position i after the marker (i=0 first)
  function automatic logic serial_bit(input logic [DW-1:0] w, input int i);
    return w[DW-1-i];
  endfunction

  task automatic pulse_bit(input logic b, input bit last);
    @(negedge clk);
    sdata = b;
    sclk  = 1'b0;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    if (!last) repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(input logic [DW-1:0] w, input bit extra_edge);
    int lat = 0;
    int hcnt = 0;
    bit seen = 1'b0;
    pulse_bit(1'b1, 1'b0);
    for (int i = 0; i < DW; i++) pulse_bit(serial_bit(w, i), i == DW - 1);
    if (extra_edge) begin
      @(negedge clk); sclk = 1'b0; lat++;
      @(negedge clk); sclk = 1'b1; lat++;
      if (valid) seen = 1'b1;
    end
    while (!seen && lat < 12) begin
      @(negedge clk);
      lat++;
      if (valid) seen = 1'b1;
    end
    check(seen && lat <= 6, "R4 latency", lat, 6);
    check(word == w, "R3 R2 word", int'(word), int'(w));
    check(vhold, "R7 hold starts with valid", int'(vhold), 1);
    hcnt = 1;
    @(negedge clk);
    check(!valid, "R4 one-cycle valid", int'(valid), 0);
    while (vhold && hcnt < 20) begin
      hcnt++;
      @(negedge clk);
    end
    check(hcnt == HOLD, "R7 hold length", hcnt, HOLD);
    check(word == w, "R5 word kept", int'(word), int'(w));
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w;
    void'($urandom(32'h5eed_0c1a));
    repeat (4) @(negedge clk);
    check(word == '0 && !valid && !vhold && !ovr, "R1 reset state",
          int'({word, valid, vhold, ovr}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(word == '0 && !valid && !vhold && !ovr, "R1 after release",
          int'({word, valid, vhold, ovr}), 0);

    // directed patterns, R2 bit order and R6 back-to-back
    send_frame('0, 1'b0);
    send_frame('1, 1'b0);
    send_frame(7'b1010101, 1'b0);
    send_frame(7'b0000001, 1'b0);
    send_frame(7'b1000000, 1'b0);
    check(!ovr, "R8 no overrun on clean frames", int'(ovr), 0);

    for (int k = 0; k < 30; k++) begin
      w = DW'($urandom);
      send_frame(w, 1'b0);   // R6 chain clean between frames
    end

    // R8: extra edge during capture window
    send_frame(7'b0110011, 1'b1);
    check(ovr, "R8 overrun set", int'(ovr), 1);
    send_frame(7'b1100101, 1'b0);   // ignored edge left nothing behind
    check(ovr, "R8 overrun sticky", int'(ovr), 1);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(!ovr && word == '0, "R1 reset clears", int'({word, ovr}), 0);
    rst_n = 1'b1;
    send_frame(7'b0011100, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule